// File: doc/BRIEF.md
# Two-Phase Strobed Register Write Master

This block turns single register-write requests into a two-phase transaction on a narrow parallel bus shared by four small slave devices. Each request names a slave (index 1 to 4), a 3-bit register offset inside that slave and a 5-bit value. The bus lives inside a 32-bit general-purpose output word. The master fills only its own address and data fields in that word. Every other bit is copied from a pass-through input, so unrelated output fields sharing the word are never disturbed.

A write first drives the offset and data with all four slave enables low. It holds that state for a setup time given in picoseconds, which is converted to whole clock cycles and rounded up. It then raises exactly one enable, the one for the chosen slave. That enable stays high after the write finishes. When the next request arrives, the master first spends one cycle with every enable low and the old offset and data still on the bus. Only then does it change the offset and data.

The controller is a five-state machine:
- `ST_IDLE`: nothing has been written since reset. All enables are low and requests are accepted.
- `ST_SETUP`: phase one. The new offset and data are on the bus, the enables are low and the setup count runs.
- `ST_STROBE`: the first cycle of phase two. `done` pulses here.
- `ST_HOLD`: phase two is held. Requests are accepted.
- `ST_DROP`: one cycle that lowers the enables before new fields are loaded.

Its transitions are:
- `ST_IDLE` to `ST_SETUP` on a valid request.
- `ST_SETUP` to `ST_STROBE` when the count expires.
- `ST_STROBE` to `ST_HOLD` unconditionally.
- `ST_HOLD` to `ST_DROP` on a valid request.
- `ST_DROP` to `ST_SETUP` unconditionally.

A request whose slave index is invalid causes no transition.

Top module: `pbus_wr_master`

## Requirements
- R1: While reset is asserted and right after it, the address field (word bits 15:9) and the data field (word bits 31:27) are zero, `req_ready` is 1, and `busy` and `done` are 0.
- R2: The address field is packed as {enable of slave 1, enable of slave 2, enable of slave 3, enable of slave 4, offset[2:0]}. Slave 1 is at bit 15, slave 4 at bit 12 and the offset at bits 11:9. The 5-bit data value sits at bits 31:27.
- R3: After a valid request is accepted, the new offset and data are driven with all four enables at 0 for exactly SETUP_CYC cycles. SETUP_CYC is the setup time divided by the clock period, rounded up: 17 cycles for 166 ns at a 10 ns clock.
- R4: In phase two, exactly one enable bit is 1, the one of the requested slave, and the offset and data are the same as in phase one.
- R5: A request with slave index 0, 5, 6 or 7 is consumed (`req_ready` is 1) but starts no transaction. The word, `busy` and `req_ready` are unchanged after it.
- R6: Word bits outside the address and data fields always equal the same bits of `gpio_keep`, including changes made while an enable is held high.
- R7: `req_ready` is 0 from the cycle after acceptance until phase two has been driven for one cycle. `done` is 1 for exactly that first phase-two cycle. `busy` is 1 from acceptance through that cycle.
- R8: The enable stays high after a write completes. A following valid request first drives one cycle with all enables 0 and the previous offset and data, and only then loads the new offset and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Master can accept a request this cycle |
| req_slave | input | 3 | Slave index, valid values 1 to 4 |
| req_off | input | 3 | Register offset inside the slave |
| req_data | input | 5 | Value to write |
| gpio_keep | input | 32 | Source for word bits not owned by the bus |
| gpio_out | output | 32 | Merged output word |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | Pulses in the first phase-two cycle |

## Verification
The bench builds the block with its default parameters: a 10 000 ps clock period and a 166 000 ps setup time, which give a 17-cycle phase one, four slaves, and the 32-bit word with fields at bits 15:9 and 31:27. These values let every cycle of phase one be observed at the pins. They also let writes to all four slaves be chained back to back, so each write after the first passes through the drop cycle with the previous fields still visible. Invalid indices are tried both before any write and while an enable is held high. The pass-through input is changed while an enable is high.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DROP
    } wr_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/pbus_fsm.sv
module pbus_fsm
    import pbus_pkg::*;
#(
    parameter int SLAVES    = 4,
    parameter int SLV_W     = 3,
    parameter int SETUP_CYC = 17,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SLV_W-1:0] req_slave,
    output logic             req_ready,
    output logic             busy,
    output logic             done,
    output logic             drive_en,
    output logic             ld_direct,
    output logic             ld_pend,
    output logic             promote
);

    wr_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept, good_idx;

    assign good_idx = (req_slave >= SLV_W'(1)) && (req_slave <= SLV_W'(SLAVES));
    assign accept   = req_valid && req_ready;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && good_idx) state_d = ST_SETUP;
            ST_SETUP:  if (cnt_q == '0) state_d = ST_STROBE;
            ST_STROBE: state_d = ST_HOLD;
            ST_HOLD:   if (accept && good_idx) state_d = ST_DROP;
            ST_DROP:   state_d = ST_SETUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and setup counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_SETUP && state_q != ST_SETUP)
                cnt_q <= CNT_W'(SETUP_CYC - 1);
            else if (state_q == ST_SETUP && cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = (state_q == ST_IDLE) || (state_q == ST_HOLD);
        busy      = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_DROP);
        done      = (state_q == ST_STROBE);
        drive_en  = (state_q == ST_STROBE) || (state_q == ST_HOLD);
        ld_direct = (state_q == ST_IDLE) && accept && good_idx;
        ld_pend   = (state_q == ST_HOLD) && accept && good_idx;
        promote   = (state_q == ST_DROP);
    end

    // Checker: cycles spent in phase one
    logic [CNT_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   run_q <= '0;
        else if (state_q == ST_SETUP) run_q <= run_q + CNT_W'(1);
        else                          run_q <= '0;
    end

    AST_SETUP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE) |-> (run_q == CNT_W'(SETUP_CYC))); // R3
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && good_idx) |=> !req_ready); // R7
    AST_BAD_INDEX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !good_idx) |=> (state_q == $past(state_q))); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

endmodule

// File: rtl/pbus_fields.sv
module pbus_fields #(
    parameter int SLV_W = 3,
    parameter int OFF_W = 3,
    parameter int DAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_direct,
    input  logic             ld_pend,
    input  logic             promote,
    input  logic             drive_en,
    input  logic [SLV_W-1:0] req_slave,
    input  logic [OFF_W-1:0] req_off,
    input  logic [DAT_W-1:0] req_data,
    output logic [SLV_W-1:0] cur_slave,
    output logic [OFF_W-1:0] cur_off,
    output logic [DAT_W-1:0] cur_dat
);

    logic [SLV_W-1:0] pend_slave;
    logic [OFF_W-1:0] pend_off;
    logic [DAT_W-1:0] pend_dat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_slave  <= '0;
            cur_off    <= '0;
            cur_dat    <= '0;
            pend_slave <= '0;
            pend_off   <= '0;
            pend_dat   <= '0;
        end else begin
            if (ld_direct) begin
                cur_slave <= req_slave;
                cur_off   <= req_off;
                cur_dat   <= req_data;
            end else if (promote) begin
                cur_slave <= pend_slave;
                cur_off   <= pend_off;
                cur_dat   <= pend_dat;
            end
            if (ld_pend) begin
                pend_slave <= req_slave;
                pend_off   <= req_off;
                pend_dat   <= req_data;
            end
        end
    end

    AST_FIELDS_FROZEN_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> ($stable(cur_off) && $stable(cur_dat))); // R4
    AST_LOWER_BEFORE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cur_off) || !$stable(cur_dat)) |-> (!drive_en && !$past(drive_en))); // R8

endmodule

// File: rtl/pbus_pack.sv
module pbus_pack #(
    parameter int SLAVES   = 4,
    parameter int SLV_W    = 3,
    parameter int OFF_W    = 3,
    parameter int DAT_W    = 5,
    parameter int WORD_W   = 32,
    parameter int ADDR_LSB = 9,
    parameter int DATA_LSB = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic [SLV_W-1:0]  cur_slave,
    input  logic [OFF_W-1:0]  cur_off,
    input  logic [DAT_W-1:0]  cur_dat,
    input  logic [WORD_W-1:0] gpio_keep,
    output logic [WORD_W-1:0] gpio_out
);

    localparam int ADDR_W = SLAVES + OFF_W;

    logic [SLAVES-1:0] en_vec;
    logic [ADDR_W-1:0] addr_fld;

    // Slave 1 takes the top enable bit, the last slave the lowest one
    for (genvar k = 0; k < SLAVES; k++) begin : g_en
        assign en_vec[SLAVES-1-k] = drive_en && (cur_slave == SLV_W'(k + 1));
    end

    assign addr_fld = {en_vec, cur_off};

    always_comb begin
        gpio_out = gpio_keep;
        gpio_out[ADDR_LSB +: ADDR_W] = addr_fld;
        gpio_out[DATA_LSB +: DAT_W]  = cur_dat;
    end

    AST_AT_MOST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gpio_out[ADDR_LSB + OFF_W +: SLAVES])); // R4
    AST_ENABLE_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> ($countones(gpio_out[ADDR_LSB + OFF_W +: SLAVES]) == 1)); // R4

endmodule

// File: rtl/pbus_wr_master.sv
module pbus_wr_master #(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int SETUP_PS      = 166000,
    parameter int SLAVES        = 4,
    parameter int OFF_W         = 3,
    parameter int DAT_W         = 5,
    parameter int WORD_W        = 32,
    parameter int ADDR_LSB      = 9,
    parameter int DATA_LSB      = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_slave,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DAT_W-1:0]  req_data,
    input  logic [WORD_W-1:0] gpio_keep,
    output logic [WORD_W-1:0] gpio_out,
    output logic              busy,
    output logic              done
);

    localparam int SLV_W     = 3;
    localparam int RAW_CYC   = pbus_pkg::ceil_div(SETUP_PS, CLK_PERIOD_PS);
    localparam int SETUP_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
    localparam int CNT_W     = $clog2(SETUP_CYC + 1);

    logic             drive_en, ld_direct, ld_pend, promote;
    logic [SLV_W-1:0] cur_slave;
    logic [OFF_W-1:0] cur_off;
    logic [DAT_W-1:0] cur_dat;

    pbus_fsm #(
        .SLAVES(SLAVES), .SLV_W(SLV_W), .SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slave(req_slave),
        .req_ready(req_ready), .busy(busy), .done(done), .drive_en(drive_en),
        .ld_direct(ld_direct), .ld_pend(ld_pend), .promote(promote)
    );

    pbus_fields #(
        .SLV_W(SLV_W), .OFF_W(OFF_W), .DAT_W(DAT_W)
    ) u_fields (
        .clk(clk), .rst_n(rst_n), .ld_direct(ld_direct), .ld_pend(ld_pend),
        .promote(promote), .drive_en(drive_en), .req_slave(req_slave),
        .req_off(req_off), .req_data(req_data), .cur_slave(cur_slave),
        .cur_off(cur_off), .cur_dat(cur_dat)
    );

    pbus_pack #(
        .SLAVES(SLAVES), .SLV_W(SLV_W), .OFF_W(OFF_W), .DAT_W(DAT_W),
        .WORD_W(WORD_W), .ADDR_LSB(ADDR_LSB), .DATA_LSB(DATA_LSB)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .cur_slave(cur_slave),
        .cur_off(cur_off), .cur_dat(cur_dat), .gpio_keep(gpio_keep),
        .gpio_out(gpio_out)
    );

endmodule

// File: tb/tb_pbus_wr_master.sv
module tb_pbus_wr_master;

    localparam int CLK_HALF = 5;
    localparam int SETUP_N  = 17;  // R3: ceil(166 ns / 10 ns)
    localparam logic [31:0] FMASK = 32'hF800_FE00;  // bits 31:27 and 15:9

    // {slave[2:0], off[2:0], data[4:0], expected address field[6:0]} (R2, R4)
    localparam logic [17:0] VEC [6] = '{
        {3'd1, 3'd5, 5'h1F, 7'h45},
        {3'd2, 3'd0, 5'h0A, 7'h20},
        {3'd3, 3'd7, 5'h15, 7'h17},
        {3'd4, 3'd2, 5'h03, 7'h0A},
        {3'd1, 3'd0, 5'h00, 7'h40},
        {3'd4, 3'd7, 5'h1F, 7'h0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_slave = '0;
    logic [2:0]  req_off = '0;
    logic [4:0]  req_data = '0;
    logic [31:0] gpio_keep = 32'hA5A5_5A5A;
    logic [31:0] gpio_out;
    logic        busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    pbus_wr_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_slave(req_slave), .req_off(req_off), .req_data(req_data),
        .gpio_keep(gpio_keep), .gpio_out(gpio_out), .busy(busy), .done(done)
    );

    always #(CLK_HALF) clk = ~clk;

    function automatic logic [31:0] mk(input logic [31:0] keep,
                                       input logic [6:0] adr, input logic [4:0] dat);
        logic [31:0] w;
        w = keep & ~FMASK;
        w[15:9]  = adr;
        w[31:27] = dat;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one write starting at a negedge; ends at the negedge of the hold state
    task automatic do_write(input logic [2:0] s, input logic [2:0] o, input logic [4:0] d,
                            input logic [6:0] exp_adr, input bit from_hold,
                            input logic [2:0] old_o, input logic [4:0] old_d);
        logic [31:0] e;
        bit ok;
        req_valid = 1'b1; req_slave = s; req_off = o; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (from_hold) begin
            // R8: one cycle with enables low and the previous fields
            e = mk(gpio_keep, {4'b0000, old_o}, old_d);
            chk(gpio_out == e && busy && !req_ready, "R8 drop cycle", gpio_out, e);
            @(negedge clk);
        end
        // R3: phase one for exactly SETUP_N cycles with enables low
        e = mk(gpio_keep, {4'b0000, o}, d);
        ok = 1'b1;
        for (int k = 0; k < SETUP_N; k++) begin
            if (gpio_out != e || !busy || req_ready || done) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R3 phase one", gpio_out, e);
        // R4 / R2: phase two, first cycle, with R7 done pulse
        e = mk(gpio_keep, exp_adr, d);
        chk(gpio_out == e, "R4 phase two word", gpio_out, e);
        chk(done && !req_ready && busy, "R7 first strobe cycle",
            {29'd0, done, req_ready, busy}, 32'd5);
        @(negedge clk);
        chk(!done && req_ready && !busy && gpio_out == e, "R8 enable held",
            gpio_out, e);
    endtask

    initial begin
        logic [31:0] snap;
        logic [2:0]  po;
        logic [4:0]  pd;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(gpio_out == (gpio_keep & ~FMASK), "R1 reset word", gpio_out, gpio_keep & ~FMASK);
        chk(req_ready && !busy && !done, "R1 reset flags",
            {29'd0, req_ready, busy, done}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: invalid index before any write
        snap = gpio_out;
        req_valid = 1'b1; req_slave = 3'd0; req_off = 3'd3; req_data = 5'h11;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(gpio_out == snap && req_ready && !busy, "R5 index 0 in idle", gpio_out, snap);
        @(negedge clk);
        chk(gpio_out == snap && !busy, "R5 idle still after index 0", gpio_out, snap);

        // Table walk (R2, R3, R4, R7, R8)
        po = '0; pd = '0;
        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][17:15], VEC[i][14:12], VEC[i][11:7], VEC[i][6:0],
                     (i != 0), po, pd);
            po = VEC[i][14:12];
            pd = VEC[i][11:7];
        end

        // R5: invalid indices while the enable is held
        for (int b = 5; b < 8; b++) begin
            snap = gpio_out;
            req_valid = 1'b1; req_slave = 3'(b); req_off = 3'd1; req_data = 5'h02;
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            chk(gpio_out == snap && req_ready && !busy, "R5 bad index in hold",
                gpio_out, snap);
        end

        // R6: pass-through follows gpio_keep with enable held
        gpio_keep = 32'h0123_4567;
        #1;
        chk(gpio_out == mk(32'h0123_4567, 7'h0F, 5'h1F), "R6 pass-through",
            gpio_out, mk(32'h0123_4567, 7'h0F, 5'h1F));
        gpio_keep = 32'hFFFF_FFFF;
        #1;
        chk(gpio_out == mk(32'hFFFF_FFFF, 7'h0F, 5'h1F), "R6 pass-through ones",
            gpio_out, mk(32'hFFFF_FFFF, 7'h0F, 5'h1F));
        @(negedge clk);

        // R2: slave 2 after slave 4 with a fresh keep value
        do_write(3'd2, 3'd6, 5'h09, 7'h26, 1'b1, 3'd7, 5'h1F);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule